// File: doc/BRIEF.md
# Cascaded Three-Channel Interval Timer

This block holds three 16-bit down-counters behind a small byte-wide register interface: one control port and one data port per counter. Counter 2 works as a prescaler. It decrements on each strobe of a master-clock enable, and its terminal-count pulse is the only count enable of counters 0 and 1. Counter 0 is meant to be loaded with the system tick divisor and drives the tick interrupt pulse. Counter 1 is meant to be loaded with the full 16-bit range and drives a timebase wrap pulse. Software can freeze counter 1 with a latch command and read the frozen value back as two bytes.

Each counter is programmed by a control byte, followed by two data writes: low byte first, then high byte. A counter is either a rate generator, which reloads and pulses once per period, or stopped in software-strobe mode, which is how software silences it. The read data is registered. It appears one clock after the read strobe and holds until the next read.

Top module: `tri_interval_timer`

## Requirements
- R1: A write to port 3 is a control byte. Bits [7:6] select counter 0, 1 or 2, and a select of 3 is ignored. Bits [5:4] give the access: 2'b11 programs the counter, 2'b00 is a latch command, and 2'b01 or 2'b10 is ignored. Bits [3:1] give the mode: 3'b010 is rate generator and any other value is software strobe. Bit 0 is ignored. Programming stops the counter, resets both byte toggles, drops any latch and raises no interrupt in the following cycle.
- R2: Writes to a counter's data port (port 0, 1 or 2) load the low byte first and then the high byte. The count takes the new 16-bit value only on the high-byte write. After a low-byte write alone, the counter holds its old count and does not count.
- R3: In rate-generator mode with reload N, the count steps N, N-1, ..., 1 on successive enables, and the enable that finds 1 reloads N. A reload of 0 acts as 65536, so the first enable gives 0xFFFF. A reload of 0xFFFF wraps every 65535 enables.
- R4: Counter 2 decrements only on cycles with `mclk_en` high. Its terminal-count pulse is the count enable of counters 0 and 1. With `mclk_en` high every cycle, counter 2 divisor D and counter 0 reload N, tick pulses are D*N cycles apart.
- R5: In software-strobe mode a counter keeps its loaded count whatever enables arrive, and it raises no interrupt.
- R6: `tick_irq` and `tbase_irq` are one-cycle pulses, one per wrap of counter 0 and counter 1 respectively.
- R7: A latch command freezes the counter's value. The next two reads of its port return the low byte and then the high byte of the frozen value. A further latch command before both bytes are read is ignored.
- R8: A read with no latch pending returns the live count, low byte first and then high byte, on the same toggle.
- R9: `rdata` is 0 after reset, takes the read byte one clock after `rd_en`, reads 0 from port 3, and holds its value when `rd_en` is low.
- R10: After reset every counter is stopped with count 0, and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_en | input | 1 | Master-clock strobe; counter 2 decrements on it |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Port: 0-2 counter data, 3 control |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| tick_irq | output | 1 | Counter 0 terminal-count pulse |
| tbase_irq | output | 1 | Counter 1 terminal-count pulse |

## Verification
The bench builds the block with its default 8-bit data ports and 16-bit counters. In this configuration the full 0-to-65536 reload wrap can be observed through the first decrement and the live-read path. The bench drives the master strobe one pulse at a time through a divide-by-2 prescaler, so every counter value after k enables can be predicted exactly. It then sweeps k across more than two periods for several small reloads, and sweeps the prescaler divisor against the counter 0 and counter 1 reloads to measure pulse spacing, both with a steady master strobe and with one that is high every other cycle.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int NUM_CH = 3;
  localparam int PRE_CH = 2;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd3;
  localparam logic [2:0] MODE_RATE = 3'b010;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0] sel;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctl_t;
endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
  import itmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0] prog_stb,
  output logic [NUM_CH-1:0] latch_stb,
  output logic [NUM_CH-1:0] wr_stb,
  output logic [NUM_CH-1:0] rd_stb,
  output logic              prog_rate
);
  ctl_t ctl;
  logic ctrl_hit;
  logic unused_bcd;

  assign ctl        = ctl_t'(wdata[7:0]);
  assign ctrl_hit   = wr_en && (addr == CTRL_ADDR);
  assign prog_rate  = (ctl.mode == MODE_RATE);
  assign unused_bcd = ctl.bcd;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign wr_stb[i]    = wr_en && (addr == ADDR_W'(i));
    assign rd_stb[i]    = rd_en && (addr == ADDR_W'(i));
    assign prog_stb[i]  = ctrl_hit && (ctl.sel == 2'(i)) && (ctl.acc == ACC_LOHI);
    assign latch_stb[i] = ctrl_hit && (ctl.sel == 2'(i)) && (ctl.acc == ACC_LATCH);
  end
endmodule

// File: rtl/itmr_channel.sv
module itmr_channel #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              prog_stb,
  input  logic              prog_rate,
  input  logic              latch_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_byte,
  output logic              tc_pulse
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  hold_q;
  logic [DATA_W-1:0] lo_q;
  logic              rate_q;
  logic              run_q;
  logic              wptr_q;
  logic              rptr_q;
  logic              lat_q;
  logic              tc_q;
  logic [CNT_W-1:0]  view;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      reload_q <= '0;
      hold_q   <= '0;
      lo_q     <= '0;
      rate_q   <= 1'b0;
      run_q    <= 1'b0;
      wptr_q   <= 1'b0;
      rptr_q   <= 1'b0;
      lat_q    <= 1'b0;
      tc_q     <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      // byte loading has priority over counting
      if (wr_stb) begin
        if (!wptr_q) begin
          lo_q   <= wr_byte;
          wptr_q <= 1'b1;
          run_q  <= 1'b0;
        end else begin
          reload_q <= {wr_byte, lo_q};
          count_q  <= {wr_byte, lo_q};
          wptr_q   <= 1'b0;
          run_q    <= rate_q;
        end
      end else if (run_q && cnt_en) begin
        if (count_q == CNT_W'(1)) begin
          count_q <= reload_q;
          tc_q    <= 1'b1;
        end else begin
          count_q <= count_q - CNT_W'(1);
        end
      end
      if (rd_stb) begin
        rptr_q <= ~rptr_q;
        if (rptr_q) lat_q <= 1'b0;
      end
      if (latch_stb && !lat_q) begin
        hold_q <= count_q;
        lat_q  <= 1'b1;
        rptr_q <= 1'b0;
      end
      if (prog_stb) begin
        rate_q <= prog_rate;
        run_q  <= 1'b0;
        wptr_q <= 1'b0;
        rptr_q <= 1'b0;
        lat_q  <= 1'b0;
        tc_q   <= 1'b0;
      end
    end
  end

  assign view     = lat_q ? hold_q : count_q;
  assign rd_byte  = rptr_q ? view[CNT_W-1:DATA_W] : view[DATA_W-1:0];
  assign tc_pulse = tc_q;
endmodule

// File: rtl/itmr_rdmux.sv
module itmr_rdmux
  import itmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_byte,
  output logic [DATA_W-1:0]              rdata
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) pick = ch_byte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= pick;
  end
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import itmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclk_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tick_irq,
  output logic              tbase_irq
);
  logic [NUM_CH-1:0]             prog_stb;
  logic [NUM_CH-1:0]             latch_stb;
  logic [NUM_CH-1:0]             wr_stb;
  logic [NUM_CH-1:0]             rd_stb;
  logic                          prog_rate;
  logic [NUM_CH-1:0]             ch_pulse;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_byte;
  logic                          pre_pulse;

  itmr_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .prog_stb  (prog_stb),
    .latch_stb (latch_stb),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .prog_rate (prog_rate)
  );

  assign pre_pulse = ch_pulse[PRE_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic en;
    if (i == PRE_CH) begin : g_pre
      assign en = mclk_en;
    end else begin : g_chain
      assign en = pre_pulse;
    end
    itmr_channel #(.DATA_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .cnt_en    (en),
      .prog_stb  (prog_stb[i]),
      .prog_rate (prog_rate),
      .latch_stb (latch_stb[i]),
      .wr_stb    (wr_stb[i]),
      .wr_byte   (wdata),
      .rd_stb    (rd_stb[i]),
      .rd_byte   (ch_byte[i]),
      .tc_pulse  (ch_pulse[i])
    );
  end

  itmr_rdmux #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .ch_byte (ch_byte),
    .rdata   (rdata)
  );

  assign tick_irq  = ch_pulse[0];
  assign tbase_irq = ch_pulse[1];
endmodule

// File: rtl/tri_interval_timer_chk.sv
module tri_interval_timer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mclk_en,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              tick_irq,
  input logic              tbase_irq,
  input logic              pre_pulse
);
  logic prog_ch0;
  assign prog_ch0 = wr_en && (addr == 2'd3) && (wdata[7:6] == 2'd0) && (wdata[5:4] == 2'b11);

  // R9
  rdata_rst_chk: assert property (@(posedge clk) rst |=> (rdata == '0));
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst) !rd_en |=> $stable(rdata));
  // R4
  pre_gate_chk: assert property (@(posedge clk) disable iff (rst) pre_pulse |-> $past(mclk_en));
  // R4
  tick_src_chk: assert property (@(posedge clk) disable iff (rst) tick_irq |-> $past(pre_pulse));
  // R6
  tbase_src_chk: assert property (@(posedge clk) disable iff (rst) tbase_irq |-> $past(pre_pulse));
  // R1
  prog_quiet_chk: assert property (@(posedge clk) disable iff (rst) prog_ch0 |=> !tick_irq);
endmodule

bind tri_interval_timer tri_interval_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mclk_en   (mclk_en),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .tick_irq  (tick_irq),
  .tbase_irq (tbase_irq),
  .pre_pulse (pre_pulse)
);

// File: tb/sim_tri_interval_timer.sv
module sim_tri_interval_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mclk_man = 1'b0;
  logic [1:0] mclk_mode = 2'd0;
  logic       phase = 1'b0;
  logic       mclk_en;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       tick_irq;
  logic       tbase_irq;

  int errors = 0;
  int checks = 0;
  int tick_cnt = 0;
  int tbase_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) phase <= ~phase;
  assign mclk_en = mclk_man | (mclk_mode == 2'd1) | ((mclk_mode == 2'd2) & phase);

  always @(posedge clk) begin
    if (tick_irq)  tick_cnt  <= tick_cnt + 1;
    if (tbase_irq) tbase_cnt <= tbase_cnt + 1;
  end

  tri_interval_timer u0 (
    .clk(clk), .rst(rst), .mclk_en(mclk_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick_irq(tick_irq), .tbase_irq(tbase_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd16(input logic [1:0] ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(ch, lo); rd(ch, hi);
    v = {hi, lo};
  endtask

  task automatic prog(input logic [1:0] ch, input bit rate, input logic [15:0] val);
    wr(2'd3, {ch, 2'b11, rate ? 3'b010 : 3'b100, 1'b0});
    wr(ch, val[7:0]);
    wr(ch, val[15:8]);
  endtask

  task automatic latch(input logic [1:0] ch);
    wr(2'd3, {ch, 2'b00, 4'b0000});
  endtask

  task automatic mpulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mclk_man = 1'b1;
      @(negedge clk); mclk_man = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gap(input bit which, output int g);
    int w = 0;
    while (!(which ? tbase_irq : tick_irq) && w < 5000) begin @(negedge clk); w++; end
    g = 0;
    do begin @(negedge clk); g++; end while (!(which ? tbase_irq : tick_irq) && g < 5000);
  endtask

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    int base, g;
    int nl [4] = '{2, 3, 5, 7};
    int dl [3] = '{2, 3, 4};

    idle(4);
    rst = 1'b0;
    idle(1);
    chk("R10 R9 rdata after reset", rdata, 0);
    chk("R10 tick_irq after reset", tick_irq, 0);
    chk("R10 tbase_irq after reset", tbase_irq, 0);
    rd16(2'd0, v);
    chk("R10 R8 counter 0 count after reset", v, 0);

    // R3 R6 R8 stepwise count and pulses for small reloads
    foreach (nl[j]) begin
      for (int k = 0; k <= 2 * nl[j] + 1; k++) begin
        prog(2'd2, 1'b1, 16'd2);
        prog(2'd0, 1'b1, 16'(nl[j]));
        base = tick_cnt;
        mpulse(2 * k);
        idle(3);
        rd16(2'd0, v);
        chk($sformatf("R3 count N=%0d k=%0d", nl[j], k), v,
            ((k % nl[j]) == 0) ? nl[j] : nl[j] - (k % nl[j]));
        chk($sformatf("R6 pulses N=%0d k=%0d", nl[j], k), tick_cnt - base, k / nl[j]);
      end
    end

    // R3 reload 0 acts as 65536
    prog(2'd2, 1'b1, 16'd2);
    prog(2'd0, 1'b1, 16'd0);
    mpulse(2); idle(3); rd16(2'd0, v);
    chk("R3 reload 0 first step", v, 16'hFFFF);
    mpulse(4); idle(3); rd16(2'd0, v);
    chk("R3 reload 0 third step", v, 16'hFFFD);
    prog(2'd1, 1'b1, 16'hFFFF);
    mpulse(10); idle(3); rd16(2'd1, v);
    chk("R3 counter 1 full-range reload", v, 16'hFFFA);

    // R4 R6 pulse spacing over prescaler and reload sweeps
    foreach (dl[d]) begin
      foreach (nl[j]) begin
        if (j < 3) begin
          mclk_mode = 2'd0;
          prog(2'd2, 1'b1, 16'(dl[d]));
          prog(2'd0, 1'b1, 16'(nl[j]));
          prog(2'd1, 1'b1, 16'(nl[j] + 2));
          mclk_mode = 2'd1;
          gap(1'b0, g);
          chk($sformatf("R4 tick spacing D=%0d N=%0d", dl[d], nl[j]), g, dl[d] * nl[j]);
          gap(1'b1, g);
          chk($sformatf("R4 R6 tbase spacing D=%0d N=%0d", dl[d], nl[j] + 2), g, dl[d] * (nl[j] + 2));
        end
      end
    end
    mclk_mode = 2'd0;
    prog(2'd2, 1'b1, 16'd2);
    prog(2'd0, 1'b1, 16'd3);
    mclk_mode = 2'd2;
    gap(1'b0, g);
    chk("R4 tick spacing with half-rate master strobe", g, 12);
    mclk_mode = 2'd0;
    idle(4);

    // R2 partial write stops counter
    prog(2'd2, 1'b1, 16'd2);
    prog(2'd0, 1'b1, 16'd4);
    wr(2'd0, 8'h09);
    base = tick_cnt;
    mpulse(12); idle(3); rd16(2'd0, v);
    chk("R2 count held after low byte only", v, 4);
    chk("R2 no pulses after low byte only", tick_cnt - base, 0);
    wr(2'd0, 8'h00);
    mpulse(4); idle(3); rd16(2'd0, v);
    chk("R2 count after high byte", v, 7);

    // R5 software strobe holds count, silent
    prog(2'd2, 1'b1, 16'd2);
    prog(2'd0, 1'b0, 16'd6);
    base = tick_cnt;
    mpulse(20); idle(3); rd16(2'd0, v);
    chk("R5 strobe mode count held", v, 6);
    chk("R5 strobe mode no pulses", tick_cnt - base, 0);
    prog(2'd0, 1'b1, 16'd3);
    mpulse(4);
    wr(2'd3, {2'b00, 2'b11, 3'b100, 1'b0});
    base = tick_cnt;
    mpulse(8); idle(3); rd16(2'd0, v);
    chk("R1 R5 reprogram to strobe stops count", v, 1);
    chk("R1 R5 reprogram to strobe silences", tick_cnt - base, 0);

    // R1 ignored control codes
    prog(2'd2, 1'b1, 16'd2);
    prog(2'd0, 1'b1, 16'd5);
    mpulse(4);
    wr(2'd3, {2'b11, 2'b11, 3'b100, 1'b0});
    mpulse(2); idle(3); rd16(2'd0, v);
    chk("R1 select 3 ignored", v, 2);
    wr(2'd3, {2'b00, 2'b01, 3'b100, 1'b0});
    mpulse(2); idle(3); rd16(2'd0, v);
    chk("R1 access 01 ignored", v, 1);

    // R7 latch
    prog(2'd2, 1'b1, 16'd2);
    prog(2'd1, 1'b1, 16'h1234);
    mpulse(6); idle(3);
    latch(2'd1);
    mpulse(10); idle(3);
    rd(2'd1, b);
    chk("R7 latched low byte", b, 8'h31);
    latch(2'd1);
    mpulse(4); idle(3);
    rd(2'd1, b);
    chk("R7 second latch ignored, high byte", b, 8'h12);
    latch(2'd1);
    rd16(2'd1, v);
    chk("R7 new latch after full read", v, 16'h122A);
    rd16(2'd1, v);
    chk("R8 live read counter 1", v, 16'h122A);

    // R9 control port and hold
    rd(2'd3, b);
    chk("R9 control port reads 0", b, 0);
    rd(2'd1, b);
    idle(3);
    chk("R9 rdata holds without read", rdata, 8'h2A);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule